// File: doc/BRIEF.md
# Real-Time Clock Time Base and Event Flags

This block is the timing and interrupt-status part of a PC-style real-time clock. It counts a 32.768 kHz tick input with a single free-running divider counter. From that counter it makes a once-per-second update pulse and a periodic pulse at a programmable power-of-two rate. A status register records periodic, alarm and update events. It raises an interrupt request when an event is set and its enable bit is on. The time-of-day counter and the alarm comparator sit outside this block. The alarm comparator reports a match through a one-cycle input.

Software reaches three byte-wide registers through a pair of ports: an index port and a data port. Register A (offset 0x0A) holds a divider-mode field and a rate field. Register B (offset 0x0B) holds the halt bit and the three interrupt enables. Register C (offset 0x0C) holds the event flags and the summary interrupt bit. Reading register C clears it. When the divider is released it starts at its half-way point, so the first update pulse comes half a second after release and later ones come every second.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, register A reads 0x70, register B reads 0x00, register C reads 0x00, the index is 0x00, and irq, update_pulse and periodic_pulse are low.
- R2: A write to the index port selects the offset for every later data access until the index is written again. A data write stores bits 6:0 into register A at 0x0A (bit 7 reads as 0) and all 8 bits into register B at 0x0B. Data writes to 0x0C and to any other offset are ignored. A data read returns the selected register on host_rdata one cycle after the read strobe, and unknown offsets read 0x00.
- R3: The divider runs only while register A bits 6:4 equal 3'b010. Any other value holds it at its half-way point. With one tick per cycle, the first update_pulse comes exactly 2^(DIV_W-1) cycles after the releasing write edge, and later ones come every 2^DIV_W cycles.
- R4: Register A bits 3:0 hold the rate r. r = 0 gives no periodic pulses. For r of 1 to 15, periodic_pulse fires every 2^(r-1) ticks, aligned to the divider. At r = 7 with DIV_W = 15, exactly 256 pulses fall from release up to and including the first update.
- R5: Changing the rate while the divider runs takes effect without moving the update phase. The update interval stays 2^DIV_W ticks.
- R6: While register B bit 7 (halt) is set, no update pulse is produced and the update flag is not set. Periodic pulses continue.
- R7: Register C bit 6 (periodic), bit 5 (alarm) and bit 4 (update) are set whatever the enables hold. A periodic or update flag sets one cycle after its pulse. The alarm flag sets at the edge that samples alarm_in.
- R8: A data read of register C returns its value and clears all flags at the same edge. An event arriving in the cycle of that read stays set.
- R9: Register C bit 7 and irq are high while any flag is set together with its enable in register B (bit 6 periodic, bit 5 alarm, bit 4 update). irq drops at the edge of the clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| alarm_in | input | 1 | One-cycle alarm match from the external comparator |
| host_addr_we | input | 1 | Write strobe for the index port |
| host_data_we | input | 1 | Write strobe for the data port |
| host_data_re | input | 1 | Read strobe for the data port |
| host_wdata | input | 8 | Write data for both ports |
| host_rdata | output | 8 | Registered read data |
| update_pulse | output | 1 | Once-per-second update pulse |
| periodic_pulse | output | 1 | Programmable periodic pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Each result has a fixed latency. Read data appears one edge after the read strobe. Pulses appear one edge after the tick that completes the divider count. A periodic or update flag, with the matching irq, appears one edge after that. An alarm flag appears at the sampling edge itself. Before each check the bench waits exactly that many edges, and it samples at the falling edge. Pulse timing is measured with a cycle counter that is sampled just after each rising edge. The interval from the releasing write to an update, or between two pulses, is compared with an exact power of two. The same check runs across a sweep of every rate from 1 to 14.

// File: rtl/rtcp_pkg.sv
`timescale 1ns/1ps
package rtcp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned RATE_W = 4;
  localparam logic [DATA_W-1:0] OFF_A = 8'h0A;
  localparam logic [DATA_W-1:0] OFF_B = 8'h0B;
  localparam logic [DATA_W-1:0] OFF_C = 8'h0C;
  localparam logic [2:0] DIV_RUN = 3'b010;
  localparam logic [6:0] A_RESET = 7'h70;
  localparam logic [DATA_W-1:0] B_RESET = 8'h00;

  typedef struct packed {
    logic periodic;
    logic alarm;
    logic update;
  } evt_t;
endpackage

// File: rtl/rtc_host_port.sv
`timescale 1ns/1ps
module rtc_host_port
  import rtcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [DATA_W-1:0] wdata,
  input  evt_t              flags_i,
  input  logic              irq_i,
  output logic [6:0]        a_q,
  output logic [DATA_W-1:0] b_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              c_read_o
);
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] rd_mux;

  assign c_read_o = data_re && (idx_q == OFF_C);

  always_comb begin
    unique case (idx_q)
      OFF_A:   rd_mux = {1'b0, a_q};
      OFF_B:   rd_mux = b_q;
      OFF_C:   rd_mux = {irq_i, flags_i.periodic, flags_i.alarm, flags_i.update, 4'b0000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      a_q     <= A_RESET;
      b_q     <= B_RESET;
      rdata_q <= '0;
    end else begin
      if (addr_we) idx_q <= wdata;
      if (data_we && idx_q == OFF_A) a_q <= wdata[6:0];
      if (data_we && idx_q == OFF_B) b_q <= wdata;
      if (data_re) rdata_q <= rd_mux;
    end
  end

  // R2: a data write to register A lands one edge later
  assert_a_write_R2: assert property (@(posedge clk) disable iff (rst)
    (data_we && idx_q == OFF_A) |=> (a_q == $past(wdata[6:0])));
endmodule

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider
  import rtcp_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              halt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              update_o,
  output logic              periodic_o
);
  localparam logic [DIV_W-1:0] MID = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W-1:0] tap_mask;

  assign cnt_nx = cnt_q + DIV_W'(1);

  always_comb begin
    if (rate_i == '0) tap_mask = '0;
    else tap_mask = (DIV_W'(1) << (rate_i - RATE_W'(1))) - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= MID;
      update_o   <= 1'b0;
      periodic_o <= 1'b0;
    end else begin
      update_o   <= 1'b0;
      periodic_o <= 1'b0;
      if (!run_i) begin
        cnt_q <= MID;
      end else if (tick_i) begin
        cnt_q      <= cnt_nx;
        update_o   <= (cnt_nx == '0) && !halt_i;
        periodic_o <= (rate_i != '0) && ((cnt_nx & tap_mask) == '0);
      end
    end
  end

  // R3: a stopped divider sits at its half-way point
  assert_hold_mid_R3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == MID));
  // R6: no update pulse follows a cycle with halt set
  assert_no_update_halted_R6: assert property (@(posedge clk) disable iff (rst)
    update_o |-> ($past(halt_i) == 1'b0));
endmodule

// File: rtl/rtc_event_flags.sv
`timescale 1ns/1ps
module rtc_event_flags
  import rtcp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  evt_t set_i,
  input  logic clear_i,
  input  evt_t en_i,
  output evt_t flags_q,
  output logic irq_q
);
  evt_t flag_d;

  always_comb begin
    flag_d = clear_i ? evt_t'('0) : flags_q;
    flag_d = flag_d | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flag_d;
      irq_q   <= |(flag_d & en_i);
    end
  end

  // R8: a clearing read with no new event empties the register
  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    (clear_i && set_i == '0) |=> (flags_q == '0));
  // R7: an update event is captured one edge later
  assert_update_captured_R7: assert property (@(posedge clk) disable iff (rst)
    set_i.update |=> flags_q.update);
  // R9: interrupt never stands without a flag
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flags_q != '0));
endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase
  import rtcp_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic       alarm_in,
  input  logic       host_addr_we,
  input  logic       host_data_we,
  input  logic       host_data_re,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       update_pulse,
  output logic       periodic_pulse,
  output logic       irq
);
  logic [6:0]        a_q;
  logic [DATA_W-1:0] b_q;
  logic              c_read;
  evt_t              flags;
  evt_t              events;
  evt_t              enables;
  logic              irq_q;

  rtc_host_port u_port (
    .clk      (clk),
    .rst      (rst),
    .addr_we  (host_addr_we),
    .data_we  (host_data_we),
    .data_re  (host_data_re),
    .wdata    (host_wdata),
    .flags_i  (flags),
    .irq_i    (irq_q),
    .a_q      (a_q),
    .b_q      (b_q),
    .rdata_q  (host_rdata),
    .c_read_o (c_read)
  );

  rtc_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_in),
    .run_i      (a_q[6:4] == DIV_RUN),
    .halt_i     (b_q[7]),
    .rate_i     (a_q[3:0]),
    .update_o   (update_pulse),
    .periodic_o (periodic_pulse)
  );

  assign events  = '{periodic: periodic_pulse, alarm: alarm_in, update: update_pulse};
  assign enables = '{periodic: b_q[6], alarm: b_q[5], update: b_q[4]};

  rtc_event_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (events),
    .clear_i (c_read),
    .en_i    (enables),
    .flags_q (flags),
    .irq_q   (irq_q)
  );

  assign irq = irq_q;
endmodule

// File: tb/rtc_timebase_bench.sv
`timescale 1ns/1ps
module rtc_timebase_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0, alarm_in = 1'b0;
  logic host_addr_we = 1'b0, host_data_we = 1'b0, host_data_re = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic update_pulse, periodic_pulse, irq;

  int checks = 0, errors = 0;
  int cyc = 0, upd_cnt = 0, per_cnt = 0, last_upd = 0;
  int w_edge = 0;
  bit done = 1'b0;

  rtc_timebase u_rtc_timebase (
    .clk(clk), .rst(rst), .tick_in(tick_in), .alarm_in(alarm_in),
    .host_addr_we(host_addr_we), .host_data_we(host_data_we),
    .host_data_re(host_data_re), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .update_pulse(update_pulse),
    .periodic_pulse(periodic_pulse), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (update_pulse) begin upd_cnt = upd_cnt + 1; last_upd = cyc; end
    if (periodic_pulse) per_cnt = per_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_index(input logic [7:0] o);
    @(negedge clk); host_addr_we = 1'b1; host_wdata = o;
    @(negedge clk); host_addr_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); host_data_we = 1'b1; host_wdata = d;
    @(negedge clk); host_data_we = 1'b0; w_edge = cyc;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); host_data_re = 1'b1;
    @(negedge clk); host_data_re = 1'b0; v = host_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] o, input logic [7:0] d);
    set_index(o); wr_data(d);
  endtask

  task automatic rd_reg(input logic [7:0] o, output logic [7:0] v);
    set_index(o); rd_data(v);
  endtask

  task automatic wait_per(output int at);
    do @(negedge clk); while (!periodic_pulse);
    at = cyc;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_in = 1'b1;
    @(negedge clk); alarm_in = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p0, p1, u0, pc0, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick_in = 1'b1;
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 pulses", int'(update_pulse | periodic_pulse), 0);
    rd_data(v); check("R1 index 0 reads 0", v, 8'h00);
    rd_reg(8'h0A, v); check("R1 reg A", v, 8'h70);
    rd_data(v); check("R2 index latched, A again", v, 8'h70);
    rd_reg(8'h0B, v); check("R1 reg B", v, 8'h00);
    rd_reg(8'h0C, v); check("R1 reg C", v, 8'h00);
    // R2 register access
    wr_reg(8'h0B, 8'h0A); rd_data(v); check("R2 reg B readback", v, 8'h0A);
    wr_data(8'h00);
    wr_reg(8'h0A, 8'hF0); rd_data(v); check("R2 reg A bit7 dropped", v, 8'h70);
    wr_reg(8'h05, 8'hFF); rd_data(v); check("R2 unknown offset", v, 8'h00);
    wr_reg(8'h0C, 8'hFF); rd_data(v); check("R2 write to C ignored", v, 8'h00);
    check("R3 held divider makes no pulses", upd_cnt + per_cnt, 0);
    // R3/R4 release with rate 7
    set_index(8'h0A);
    per_cnt = 0;
    wr_data(8'h27);
    while (upd_cnt == 0) @(negedge clk);
    check("R3 first update after half second", last_upd - w_edge, 16384);
    check("R4 periodic count at rate 7", per_cnt, 256);
    @(negedge clk);
    rd_reg(8'h0C, v); check("R7 polled flags", v, 8'h50);
    // R5 rate change keeps update phase
    prev = last_upd;
    set_index(8'h0A);
    per_cnt = 0;
    wr_data(8'h29);
    while (upd_cnt == 1) @(negedge clk);
    check("R5 update interval after rate change", last_upd - prev, 32768);
    check("R4 periodic count at rate 9", per_cnt, 128);
    // R6 halt, R4 rate sweep
    wr_reg(8'h0B, 8'h80);
    rd_reg(8'h0C, v);
    u0 = upd_cnt;
    for (int r = 1; r <= 14; r++) begin
      wr_reg(8'h0A, 8'h20 | 8'(r));
      repeat (2) @(negedge clk);
      wait_per(p0); wait_per(p1);
      check($sformatf("R4 period at rate %0d", r), p1 - p0, 1 << (r - 1));
    end
    wr_reg(8'h0A, 8'h20);
    repeat (2) @(negedge clk);
    pc0 = per_cnt;
    repeat (33000) @(negedge clk);
    check("R4 rate 0 no pulses", per_cnt - pc0, 0);
    check("R6 no update while halted", upd_cnt - u0, 0);
    rd_reg(8'h0C, v); check("R6 update flag stays clear", v, 8'h40);
    // R9 periodic interrupt
    wr_reg(8'h0B, 8'hC0);
    wr_reg(8'h0A, 8'h27);
    wait_per(p0);
    @(negedge clk);
    check("R9 irq on periodic", int'(irq), 1);
    rd_reg(8'h0C, v); check("R9 reg C with irq bit", v, 8'hC0);
    check("R9 irq drops after read", int'(irq), 0);
    wr_reg(8'h0A, 8'h20);
    repeat (2) @(negedge clk);
    rd_reg(8'h0C, v);
    // R9 alarm interrupt
    wr_reg(8'h0B, 8'hA0);
    pulse_alarm();
    check("R9 irq on alarm", int'(irq), 1);
    rd_reg(8'h0C, v); check("R9 reg C alarm irq", v, 8'hA0);
    check("R9 irq low after alarm read", int'(irq), 0);
    // R7 flag without enable
    wr_reg(8'h0B, 8'h80);
    pulse_alarm();
    @(negedge clk);
    check("R9 no irq without enable", int'(irq), 0);
    rd_reg(8'h0C, v); check("R7 alarm flag without enable", v, 8'h20);
    // R8 event during the clearing read survives
    @(negedge clk); alarm_in = 1'b1; host_data_re = 1'b1;
    @(negedge clk); alarm_in = 1'b0; host_data_re = 1'b0; v = host_rdata;
    check("R8 read during event returns old", v, 8'h00);
    rd_data(v); check("R8 event during read kept", v, 8'h20);
    rd_data(v); check("R8 read clears all", v, 8'h00);
    // R3 hold and re-release
    wr_reg(8'h0A, 8'h70);
    wr_reg(8'h0B, 8'h00);
    u0 = upd_cnt;
    wr_reg(8'h0A, 8'h20);
    while (upd_cnt == u0) @(negedge clk);
    check("R3 re-release half second", last_upd - w_edge, 16384);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule